// File: doc/BRIEF.md
# Burst address generator (linear / interleaved)

This block produces the access address for a synchronous memory controller that supports four-beat bursts. When a new access starts it captures the full external address. On each following continue cycle it produces the next address of the burst by stepping only the two low bits. The upper bits stay as they were captured.

A static order input picks one of two orderings. Linear ordering counts the low bits upward modulo four. Interleaved ordering XORs the start value with the beat number. In both modes the sequence comes back to the start value after four beats and repeats.

The controller drives a load/advance input and a stall input. Stall freezes all state, and while it is high every other input has no effect. Command decoding, data movement and the memory array are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, addr_o is all zeros.
- R2: A clock edge with stall_i low and advance_i low (load) makes addr_o equal to addr_i, as sampled at that edge, from the edge onward. The burst beat number restarts at 0.
- R3: With order_i low (linear), beat k of a burst puts (start + k) mod 4 on addr_o[1:0]. Here start is the loaded value of the two low bits. Start 2 gives 2, 3, 0, 1.
- R4: With order_i high (interleaved), beat k puts start XOR k on addr_o[1:0]. Start 1 gives 1, 0, 3, 2. Start 2 gives 2, 3, 0, 1.
- R5: The beat counter wraps after four addresses. The fifth address of a burst equals the loaded start, and the sequence repeats from there.
- R6: A clock edge with stall_i high changes neither the beat number nor the captured address, whatever advance_i and addr_i are. addr_o is unchanged after that edge.
- R7: On an advance edge (stall_i low, advance_i high), addr_o[AW-1:2] keeps the value captured at load, and addr_i is ignored.
- R8: A load edge that arrives in the middle of a burst restarts the burst at the new address, with beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | High: hold all state for this edge |
| advance_i | input | 1 | Low: load addr_i; high: step to the next beat |
| order_i | input | 1 | Static ordering select: 0 linear, 1 interleaved |
| addr_i | input | AW | External address, sampled on load edges |
| addr_o | output | AW | Current access address |

## Verification
Two pairs of functions can fall in the same cycle. The first is a stall together with a load or an advance: the bench raises stall_i while it changes addr_i and toggles advance_i, and it expects addr_o to stay exactly as it was. The second is a load in the middle of a burst: the bench issues a load after two beats, with a different start and different upper bits, and expects the new address followed by a fresh beat-0 sequence, not the next beat of the old burst. Both orderings are walked past the wrap for several start values, and each observed address is compared against a model built from the formulas in R3 and R4.

// File: rtl/burst_addr_pkg.sv
`timescale 1ns/1ps
package burst_addr_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      ord
  );
    logic [BEAT_W-1:0] r;
    case (ord)
      ORD_XOR: r = start ^ beat;
      default: r = start + beat;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
module burst_beat_ctr
  import burst_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] start_i,
  output logic [BEAT_W-1:0] start_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] start_q, beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        start_q <= start_i;
        beat_q  <= '0;
      end else begin
        beat_q  <= beat_q + 1'b1; // natural wrap after 4 beats
      end
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/burst_upper_reg.sv
`timescale 1ns/1ps
module burst_upper_reg #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (capture_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/burst_low_map.sv
`timescale 1ns/1ps
module burst_low_map
  import burst_addr_pkg::*;
(
  input  logic              order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  burst_order_e ord;

  always_comb begin
    ord   = burst_order_e'(order_i);
    low_o = beat_low(start_i, beat_i, ord);
  end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          advance_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int UW = AW - BEAT_W;

  logic              en, load;
  logic [BEAT_W-1:0] start_q, beat_q, low;
  logic [UW-1:0]     upper_q;

  assign en   = ~stall_i;
  assign load = ~advance_i;

  burst_beat_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .load_i  (load),
    .start_i (addr_i[BEAT_W-1:0]),
    .start_o (start_q),
    .beat_o  (beat_q)
  );

  burst_upper_reg #(.W(UW)) u_upper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (en & load),
    .d_i       (addr_i[AW-1:BEAT_W]),
    .q_o       (upper_q)
  );

  burst_low_map u_map (
    .order_i (order_i),
    .start_i (start_q),
    .beat_i  (beat_q),
    .low_o   (low)
  );

  assign addr_o = {upper_q, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stall_i,
  input logic          advance_i,
  input logic          order_i,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] addr_o
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !advance_i) ##1 $stable(order_i) |-> addr_o == $past(addr_i)); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && advance_i && !order_i) |=>
      (order_i || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)); // R3

  AST_XOR_STEP_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && advance_i && order_i) |=>
      (!order_i || addr_o[0] != $past(addr_o[0]))); // R4

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i ##1 $stable(order_i) |-> $stable(addr_o)); // R6

  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && advance_i) |=> $stable(addr_o[AW-1:2])); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stall_i   (stall_i),
  .advance_i (advance_i),
  .order_i   (order_i),
  .addr_i    (addr_i),
  .addr_o    (addr_o)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stall_i = 1'b0;
  logic          advance_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  // bench model
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_beat = '0;

  always #4 clk_i = ~clk_i;

  burst_addr_gen #(.AW(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .advance_i(advance_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic st, input logic adv, input logic ord,
                      input logic [AW-1:0] a, input string tag);
    logic [1:0] low;
    @(negedge clk_i);
    stall_i = st; advance_i = adv; order_i = ord; addr_i = a;
    if (!st) begin
      if (!adv) begin
        m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
      end else begin
        m_beat = m_beat + 2'd1;
      end
    end
    low = ord ? (m_start ^ m_beat) : (m_start + m_beat);
    exp_q.push_back({m_up, low});
    tag_q.push_back(tag);
  endtask

  task automatic burst(input logic ord, input logic [AW-1:0] a, input int beats, input string tag);
    step(1'b0, 1'b0, ord, a, "R2");
    for (int i = 1; i < beats; i++)
      step(1'b0, 1'b1, ord, ~a, (i >= 4) ? "R5" : tag); // R7: addr_i changed during advance
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) chk(addr_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #13;
    chk(addr_o, '0, "R1");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk(addr_o, '0, "R1");

    burst(1'b0, 12'hA52, 6, "R3");   // linear start 2: 2,3,0,1,2,3
    burst(1'b0, 12'h3C7, 5, "R3");   // linear start 3
    burst(1'b1, 12'h5E1, 6, "R4");   // xor start 1: 1,0,3,2,1,0
    burst(1'b1, 12'h0F2, 5, "R4");   // xor start 2
    burst(1'b1, 12'h7B3, 4, "R4");   // xor start 3

    // R6: stall during burst with advance and with load
    step(1'b0, 1'b0, 1'b0, 12'h440, "R2");
    step(1'b0, 1'b1, 1'b0, 12'h000, "R3");
    step(1'b1, 1'b1, 1'b0, 12'hFFF, "R6");
    step(1'b1, 1'b0, 1'b0, 12'h9A3, "R6");
    step(1'b0, 1'b1, 1'b0, 12'h9A3, "R7");

    // R8: load mid-burst restarts at beat 0
    step(1'b0, 1'b0, 1'b1, 12'h861, "R2");
    step(1'b0, 1'b1, 1'b1, 12'h000, "R4");
    step(1'b0, 1'b1, 1'b1, 12'h000, "R4");
    step(1'b0, 1'b0, 1'b1, 12'h2DE, "R8");
    step(1'b0, 1'b1, 1'b1, 12'h111, "R8");
    step(1'b0, 1'b1, 1'b1, 12'h111, "R8");

    repeat (3) @(posedge clk_i);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule